// File: doc/BRIEF.md
# CardBus Bridge Window Decoder

This block holds the address-window part of a CardBus bridge configuration header and decides which upstream accesses the bridge claims for the card side. Two memory windows and two I/O windows are each set by a base register and a limit register. A command register carries the I/O-space and memory-space enable bits. A read-only subsystem identification word is also provided.

Software programs the windows through a simple configuration port. The port takes a dword index, write data and a write strobe, and returns read data for the addressed dword combinationally. A separate check port takes a space selector (memory or I/O), an address and an access size in bytes. For every cycle it answers whether the bridge claims that access. Memory windows have 4 KB granularity, so the last page named by the limit is included. I/O windows have dword granularity and use a size-aware upper-bound test. The writable bits of each window are set by a mask parameter. The two lowest bits of each I/O base mask also act as hardwired read-only capability bits.

Top module: `cb_window_decoder`

## Requirements
- R1: After reset every window register and the command register read zero. The exception is each I/O base register, whose bits 1:0 read as its hardwired capability value (window 0: 2'b01, window 1: 2'b00 by default). No access is claimed after reset.
- R2: A write to a memory base or memory limit register stores the write data ANDed with that window's writable mask (default 32'hFFFF_F000 for both windows), and the stored value reads back.
- R3: A write to an I/O base register stores (data AND mask) with bits 1:0 replaced by the mask's bits 1:0. The default masks are 32'hFFFF_FFFD for window 0 and 32'h0000_FFFC for window 1. A write to an I/O limit register stores data AND mask.
- R4: The eight window registers are separate storage. Writing one never changes another. In particular, window 1 registers never alias onto window 0.
- R5: The command register at dword index 1 keeps bit 0 (I/O space enable) and bit 1 (memory space enable). All its other bits read zero.
- R6: A memory access is claimed when command bit 1 is set and, for either memory window, base <= address < limit + 32'h1000.
- R7: With command bit 1 clear, no memory access is claimed.
- R8: An I/O access is claimed when command bit 0 is set and, for either I/O window, address >= (base with bits 1:0 cleared) and address + size < (limit with bits 1:0 cleared) + 4. The sum is computed without wrap.
- R9: With command bit 0 clear, no I/O access is claimed.
- R10: Dword index 16 reads the subsystem device ID in bits 31:16 and the subsystem vendor ID in bits 15:0 (defaults 16'h1A2B and 16'h3C4D).
- R11: Dword indices other than 1, 7 to 14 and 16 read zero, and writes to them change nothing.
- R12: The space selector picks the window set. Memory windows never claim an I/O access, and I/O windows never claim a memory access.
- R13: Register indices: memory base/limit of window k at 7+2k / 8+2k, I/O base/limit of window k at 11+2k / 12+2k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| acc_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| acc_addr | input | 32 | Access address |
| acc_size | input | 3 | Access size in bytes (1 to 4) |
| acc_hit | output | 1 | Access is claimed by the bridge |

## Verification
Memory probes are placed one byte below each base, at the base, at the last byte of the extended page, and at the first byte past it. These separate an inclusive from an exclusive bound and show whether the 4 KB extension is applied. I/O probes use the same start address with sizes 1, 2 and 4 against the limit. This shows the strict size-aware compare: a four-byte access ending exactly at the bound is refused, while a two-byte one is accepted. Cross-space probes and enable-bit toggles show that each enable gates only its own space. Masked write patterns with ones in every bit expose the writable masks and the hardwired I/O capability bits.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int DW    = 32;
  localparam int CFG_AW = 6;
  localparam int SZ_W  = 3;
  localparam int NWIN  = 2;

  localparam logic [CFG_AW-1:0] IDX_CMD    = 6'd1;
  localparam logic [CFG_AW-1:0] IDX_SUBSYS = 6'd16;

  function automatic logic [CFG_AW-1:0] idx_mem_base(input int k);
    return CFG_AW'(7 + 2 * k);
  endfunction
  function automatic logic [CFG_AW-1:0] idx_mem_lim(input int k);
    return CFG_AW'(8 + 2 * k);
  endfunction
  function automatic logic [CFG_AW-1:0] idx_io_base(input int k);
    return CFG_AW'(11 + 2 * k);
  endfunction
  function automatic logic [CFG_AW-1:0] idx_io_lim(input int k);
    return CFG_AW'(12 + 2 * k);
  endfunction

  // Exclusive upper bound of a memory window: whole last 4 KB page included.
  function automatic logic [DW:0] mem_top(input logic [DW-1:0] lim);
    return {1'b0, lim} + (DW+1)'(32'h1000);
  endfunction
  // Lower bound of an I/O window: capability bits dropped.
  function automatic logic [DW:0] io_floor(input logic [DW-1:0] base);
    return {1'b0, base & ~32'h3};
  endfunction
  // Exclusive upper bound of an I/O window: dword granularity.
  function automatic logic [DW:0] io_top(input logic [DW-1:0] lim);
    return {1'b0, lim & ~32'h3} + (DW+1)'(4);
  endfunction
  // End of an access (first byte past it), no wrap.
  function automatic logic [DW:0] acc_end(input logic [DW-1:0] a,
                                          input logic [SZ_W-1:0] sz);
    return {1'b0, a} + (DW+1)'(sz);
  endfunction
endpackage

// File: rtl/cbw_cfg_regs.sv
module cbw_cfg_regs
  import cbw_pkg::*;
#(
  parameter logic [NWIN-1:0][DW-1:0] MEM_MASK = {32'hFFFF_F000, 32'hFFFF_F000},
  parameter logic [NWIN-1:0][DW-1:0] IO_MASK  = {32'h0000_FFFC, 32'hFFFF_FFFD},
  parameter logic [15:0] SUB_DEV = 16'h1A2B,
  parameter logic [15:0] SUB_VEN = 16'h3C4D
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [CFG_AW-1:0]          addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [NWIN-1:0][DW-1:0]    mem_base,
  output logic [NWIN-1:0][DW-1:0]    mem_lim,
  output logic [NWIN-1:0][DW-1:0]    io_base,
  output logic [NWIN-1:0][DW-1:0]    io_lim,
  output logic                       cmd_io,
  output logic                       cmd_mem
);
  // Command register: only the two space enables are kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_io  <= 1'b0;
      cmd_mem <= 1'b0;
    end else if (we && addr == IDX_CMD) begin
      cmd_io  <= wdata[0];
      cmd_mem <= wdata[1];
    end
  end

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam logic [DW-1:0] IO_CAP = {30'b0, IO_MASK[k][1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_base[k] <= '0;
        mem_lim[k]  <= '0;
        io_base[k]  <= IO_CAP;
        io_lim[k]   <= '0;
      end else if (we) begin
        if (addr == idx_mem_base(k)) mem_base[k] <= wdata & MEM_MASK[k];
        if (addr == idx_mem_lim(k))  mem_lim[k]  <= wdata & MEM_MASK[k];
        if (addr == idx_io_base(k))
          io_base[k] <= (wdata & IO_MASK[k] & ~32'h3) | IO_CAP;
        if (addr == idx_io_lim(k))   io_lim[k]   <= wdata & IO_MASK[k];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == IDX_CMD)    rdata = {30'b0, cmd_mem, cmd_io};
    if (addr == IDX_SUBSYS) rdata = {SUB_DEV, SUB_VEN};
    for (int k = 0; k < NWIN; k++) begin
      if (addr == idx_mem_base(k)) rdata = mem_base[k];
      if (addr == idx_mem_lim(k))  rdata = mem_lim[k];
      if (addr == idx_io_base(k))  rdata = io_base[k];
      if (addr == idx_io_lim(k))   rdata = io_lim[k];
    end
  end
endmodule

// File: rtl/cbw_window_match.sv
module cbw_window_match
  import cbw_pkg::*;
#(
  parameter bit IS_IO = 1'b0
) (
  input  logic [DW-1:0]   base,
  input  logic [DW-1:0]   lim,
  input  logic [DW-1:0]   addr,
  input  logic [SZ_W-1:0] size,
  output logic            in_range
);
  if (IS_IO) begin : g_io
    // Size-aware, strictly-below upper compare.
    assign in_range = ({1'b0, addr} >= io_floor(base)) &&
                      (acc_end(addr, size) < io_top(lim));
  end else begin : g_mem
    logic unused_size;
    assign unused_size = ^size;
    assign in_range = ({1'b0, addr} >= {1'b0, base}) &&
                      ({1'b0, addr} < mem_top(lim)) && (unused_size | 1'b1);
  end
endmodule

// File: rtl/cb_window_decoder.sv
module cb_window_decoder
  import cbw_pkg::*;
#(
  parameter logic [NWIN-1:0][DW-1:0] MEM_MASK = {32'hFFFF_F000, 32'hFFFF_F000},
  parameter logic [NWIN-1:0][DW-1:0] IO_MASK  = {32'h0000_FFFC, 32'hFFFF_FFFD},
  parameter logic [15:0] SUB_DEV = 16'h1A2B,
  parameter logic [15:0] SUB_VEN = 16'h3C4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_is_io,
  input  logic [31:0]       acc_addr,
  input  logic [2:0]        acc_size,
  output logic              acc_hit
);
  logic [NWIN-1:0][DW-1:0] mem_base, mem_lim, io_base, io_lim;
  logic                    cmd_io, cmd_mem;
  logic [NWIN-1:0]         mem_in, io_in;
  logic                    mem_hit_any, io_hit_any;
  logic [NWIN-1:0][1:0]    io_cap;

  cbw_cfg_regs #(
    .MEM_MASK(MEM_MASK), .IO_MASK(IO_MASK),
    .SUB_DEV(SUB_DEV), .SUB_VEN(SUB_VEN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .mem_base(mem_base), .mem_lim(mem_lim),
    .io_base(io_base), .io_lim(io_lim),
    .cmd_io(cmd_io), .cmd_mem(cmd_mem)
  );

  for (genvar k = 0; k < NWIN; k++) begin : g_match
    assign io_cap[k] = IO_MASK[k][1:0];

    cbw_window_match #(.IS_IO(1'b0)) u_mem (
      .base(mem_base[k]), .lim(mem_lim[k]),
      .addr(acc_addr), .size(acc_size), .in_range(mem_in[k])
    );
    cbw_window_match #(.IS_IO(1'b1)) u_io (
      .base(io_base[k]), .lim(io_lim[k]),
      .addr(acc_addr), .size(acc_size), .in_range(io_in[k])
    );
  end

  assign mem_hit_any = cmd_mem && (|mem_in);
  assign io_hit_any  = cmd_io  && (|io_in);
  assign acc_hit     = acc_is_io ? io_hit_any : mem_hit_any;
endmodule

// File: rtl/cbw_checker.sv
module cbw_checker
  import cbw_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [CFG_AW-1:0]       cfg_addr,
  input logic [DW-1:0]           cfg_rdata,
  input logic                    acc_is_io,
  input logic                    acc_hit,
  input logic                    cmd_io,
  input logic                    cmd_mem,
  input logic                    mem_hit_any,
  input logic                    io_hit_any,
  input logic [NWIN-1:0][DW-1:0] mem_base,
  input logic [NWIN-1:0][DW-1:0] mem_lim,
  input logic [NWIN-1:0][DW-1:0] io_base,
  input logic [NWIN-1:0][DW-1:0] io_lim,
  input logic [NWIN-1:0][1:0]    io_cap
);
  logic known_idx;
  assign known_idx = (cfg_addr == 6'd1) || (cfg_addr == 6'd16) ||
                     (cfg_addr >= 6'd7 && cfg_addr <= 6'd14);

  // R7: memory enable clear -> no memory claim
  p_no_mem_claim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_is_io && !cmd_mem) |-> !acc_hit);

  // R9: I/O enable clear -> no I/O claim
  p_no_io_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_is_io && !cmd_io) |-> !acc_hit);

  // R12: a claim follows only the window set of the selected space
  p_space_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (acc_is_io ? io_hit_any : mem_hit_any));

  // R3: hardwired capability bits of both I/O bases
  p_io_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_base[0][1:0] == io_cap[0]) && (io_base[1][1:0] == io_cap[1]));

  // R4: a window-1 memory base write leaves window 0 untouched
  p_no_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 6'd9) |=> $stable(mem_base[0]));

  // R11: unknown indices read zero
  p_unimpl_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !known_idx |-> (cfg_rdata == '0));

  // R11: writes to unknown indices change no state
  p_unimpl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !known_idx) |=>
      $stable({mem_base, mem_lim, io_base, io_lim, cmd_io, cmd_mem}));
endmodule

bind cb_window_decoder cbw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .acc_is_io(acc_is_io), .acc_hit(acc_hit),
  .cmd_io(cmd_io), .cmd_mem(cmd_mem),
  .mem_hit_any(mem_hit_any), .io_hit_any(io_hit_any),
  .mem_base(mem_base), .mem_lim(mem_lim),
  .io_base(io_base), .io_lim(io_lim), .io_cap(io_cap)
);

// File: tb/cb_window_decoder_test.sv
module cb_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_is_io = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_size = 3'd1;
  logic        acc_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cb_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_is_io(acc_is_io), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_hit(acc_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(req, cfg_rdata, exp);
  endtask

  task automatic probe(input string req, input bit io, input logic [31:0] a,
                       input logic [2:0] sz, input bit exp);
    @(negedge clk);
    acc_is_io = io; acc_addr = a; acc_size = sz;
    #1 check(req, {31'b0, acc_hit}, {31'b0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 mem base0", 6'd7, 32'h0);
    rd_chk("R1 mem lim1", 6'd10, 32'h0);
    rd_chk("R1 io base0 cap", 6'd11, 32'h1);
    rd_chk("R1 io base1 cap", 6'd13, 32'h0);
    rd_chk("R1 cmd", 6'd1, 32'h0);
    probe("R1 mem probe", 1'b0, 32'h0, 3'd1, 1'b0);
    probe("R1 io probe", 1'b1, 32'h0, 3'd1, 1'b0);
  endtask

  task automatic t_masks;
    wr(6'd7, 32'h1234_5678);
    rd_chk("R2 mem base0 mask", 6'd7, 32'h1234_5000);
    wr(6'd10, 32'hFFFF_FFFF);
    rd_chk("R2 mem lim1 mask", 6'd10, 32'hFFFF_F000);
    wr(6'd11, 32'h0000_1236);
    rd_chk("R3 io base0", 6'd11, 32'h0000_1235);
    wr(6'd13, 32'h0012_3457);
    rd_chk("R3 io base1", 6'd13, 32'h0000_3454);
    wr(6'd12, 32'h0000_0013);
    rd_chk("R3 io lim0", 6'd12, 32'h0000_0011);
  endtask

  task automatic t_isolation;
    wr(6'd9, 32'hAAAA_A000);
    rd_chk("R4 base0 kept", 6'd7, 32'h1234_5000);
    rd_chk("R4 base1 own", 6'd9, 32'hAAAA_A000);
    rd_chk("R13 lim0 idx", 6'd8, 32'h0);
  endtask

  task automatic t_cmd_sub;
    wr(6'd1, 32'hFFFF_FFFF);
    rd_chk("R5 cmd bits", 6'd1, 32'h0000_0003);
    rd_chk("R10 subsystem", 6'd16, 32'h1A2B_3C4D);
  endtask

  task automatic t_unimpl;
    wr(6'd5, 32'hDEAD_BEEF);
    rd_chk("R11 read unimpl", 6'd5, 32'h0);
    rd_chk("R11 read top idx", 6'd63, 32'h0);
    rd_chk("R11 state kept", 6'd7, 32'h1234_5000);
    rd_chk("R11 cmd kept", 6'd1, 32'h0000_0003);
  endtask

  task automatic t_mem;
    wr(6'd7, 32'h1000_0000); wr(6'd8, 32'h1000_2000);
    wr(6'd9, 32'h8000_0000); wr(6'd10, 32'h8000_0000);
    wr(6'd1, 32'h2);
    probe("R6 at base", 1'b0, 32'h1000_0000, 3'd4, 1'b1);
    probe("R6 below base", 1'b0, 32'h0FFF_FFFF, 3'd1, 1'b0);
    probe("R6 last byte", 1'b0, 32'h1000_2FFF, 3'd1, 1'b1);
    probe("R6 past page", 1'b0, 32'h1000_3000, 3'd1, 1'b0);
    probe("R6 win1 in", 1'b0, 32'h8000_0FFC, 3'd4, 1'b1);
    probe("R6 win1 out", 1'b0, 32'h8000_1000, 3'd1, 1'b0);
    wr(6'd1, 32'h1);
    probe("R7 mem disabled", 1'b0, 32'h1000_0000, 3'd4, 1'b0);
  endtask

  task automatic t_io;
    wr(6'd11, 32'h0000_1000); wr(6'd12, 32'h0000_10FC);
    wr(6'd13, 32'h0000_2000); wr(6'd14, 32'h0000_2000);
    wr(6'd1, 32'h1);
    probe("R8 start dword", 1'b1, 32'h0000_1000, 3'd4, 1'b1);
    probe("R8 end at bound", 1'b1, 32'h0000_10FC, 3'd4, 1'b0);
    probe("R8 short end", 1'b1, 32'h0000_10FC, 3'd2, 1'b1);
    probe("R8 below base", 1'b1, 32'h0000_0FFF, 3'd1, 1'b0);
    probe("R8 win1 byte", 1'b1, 32'h0000_2000, 3'd1, 1'b1);
    probe("R8 win1 dword", 1'b1, 32'h0000_2000, 3'd4, 1'b0);
    wr(6'd1, 32'h2);
    probe("R9 io disabled", 1'b1, 32'h0000_1000, 3'd4, 1'b0);
  endtask

  task automatic t_space;
    wr(6'd1, 32'h3);
    probe("R12 io at mem addr", 1'b1, 32'h1000_0000, 3'd1, 1'b0);
    probe("R12 mem at io addr", 1'b0, 32'h0000_1000, 3'd1, 1'b0);
    probe("R12 io own", 1'b1, 32'h0000_1000, 3'd4, 1'b1);
    probe("R12 mem own", 1'b0, 32'h1000_0000, 3'd4, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_isolation();
    t_cmd_sub();
    t_unimpl();
    t_mem();
    t_io();
    t_space();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule